// File: doc/BRIEF.md
# Low-Bit Group Partial-Sum Shift Accumulator

This block forms the integer partial sum of one convolution group. A group is the K×K kernel window of a single input channel. Every weight and activation element in the group shares the same group-level scale factors, so only the element-level sign, exponent and mantissa reach this block. Each element is a sign bit, an `EXP_W`-bit exponent code and a `MAN_W`-bit mantissa. For each accepted pair the block restores the hidden one on both fractions and multiplies the two small fractions. It then shifts the product left by an amount set by the two exponent codes, applies the combined sign, and adds or subtracts the term in a plain signed integer accumulator.

A stream of weight/activation pairs arrives with `in_valid`. `in_first` marks the first pair of a group and `in_last` marks the final pair. The finished integer sum then appears on `out_psum` with a one-cycle `out_valid` pulse. A downstream stage applies the tensor and group scale factors. Because the largest exponent sum keeps the least significant bits, the result is an exact fixed-point sum with no rounding inside the group.

Top module: `lowbit_group_mac`

## Requirements
- R1: The value of a pair with exponent codes Ew, Ea in 1..Emax and mantissas Mw, Ma is (2^MAN_W + Mw)·(2^MAN_W + Ma)·2^(2·Emax − Ew − Ea), where Emax = 2^EXP_W − 1. With the defaults (EXP_W=2, MAN_W=4) the largest magnitude is 31·31·16 = 15376, which fits 14 bits.
- R2: If either operand has exponent code 0, the pair contributes zero, whatever its mantissas and signs.
- R3: The sign bits use 1 for negative. The term is negative when exactly one sign bit is 1, and a negative term is subtracted from the accumulator.
- R4: A pair accepted with `in_first` high starts a new sum from that pair's term alone. Any earlier contents are discarded, including an unfinished group that never saw `in_last`.
- R5: Cycles with `in_valid` low leave the sum unchanged, whatever the other inputs carry. A group's result is the exact sum of the terms of its accepted pairs.
- R6: `out_valid` is high for exactly one cycle, on the second rising edge after the edge that accepts a pair with `in_last` high. It is never high at any other time.
- R7: `out_psum` holds its value in every cycle in which `out_valid` is low.
- R8: `ACC_W` defaults to the term width (2·MAN_W + 2^(EXP_W+1) − 2) plus ceil(log2(K·K)) plus one sign bit, which is 19 bits for the defaults. A group of K·K full-scale terms of either sign is summed exactly (±138384 for the defaults).
- R9: While `rst_n` is low, `out_valid` is 0 and `out_psum` is 0.
- R10: A group whose first pair immediately follows the previous group's last pair produces its own correct result, one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pair present this cycle |
| in_first | input | 1 | Pair is the first of a group |
| in_last | input | 1 | Pair is the last of a group |
| w_sgn | input | 1 | Weight sign, 1 = negative |
| w_exp | input | EXP_W | Weight exponent code, 0 = zero element |
| w_man | input | MAN_W | Weight mantissa |
| a_sgn | input | 1 | Activation sign, 1 = negative |
| a_exp | input | EXP_W | Activation exponent code, 0 = zero element |
| a_man | input | MAN_W | Activation mantissa |
| out_valid | output | 1 | One-cycle strobe: out_psum carries a new group sum |
| out_psum | output | ACC_W | Signed integer partial sum of the group |

## Verification
The assertions check four rules on every cycle. Each result pulse is traced back to exactly one accepted last pair two edges earlier, and every last pair produces its pulse. The held sum stays stable between pulses, and each reported sum lies within K·K full-scale terms. A single-pair group with a zero exponent code is also checked to report zero. The arithmetic itself can only be shown by the bench's scenarios: the exact product-and-shift value for every sign, exponent and mantissa combination, and subtraction for mixed signs. Those scenarios also cover clearing on a new first pair, immunity to idle-cycle garbage, and full-scale sums.

// File: rtl/lbmac_pkg.sv
package lbmac_pkg;

    // Largest exponent code for an exponent field of ew bits.
    function automatic int emax_of(input int ew);
        return (1 << ew) - 1;
    endfunction

    // Width of one shifted product magnitude.
    function automatic int term_width(input int ew, input int mw);
        return 2 * mw + (1 << (ew + 1)) - 2;
    endfunction

endpackage

// File: rtl/lbmac_term.sv
module lbmac_term
    import lbmac_pkg::*;
#(
    parameter int EXP_W  = 2,
    parameter int MAN_W  = 4,
    parameter int TERM_W = term_width(EXP_W, MAN_W)
) (
    input  logic                     w_sgn,
    input  logic [EXP_W-1:0]         w_exp,
    input  logic [MAN_W-1:0]         w_man,
    input  logic                     a_sgn,
    input  logic [EXP_W-1:0]         a_exp,
    input  logic [MAN_W-1:0]         a_man,
    output logic signed [TERM_W:0]   term
);
    localparam int FRAC_W = MAN_W + 1;
    localparam int PROD_W = 2 * FRAC_W;
    localparam int SH_W   = EXP_W + 1;
    localparam int EMAX   = emax_of(EXP_W);
    localparam logic [SH_W-1:0] SH_BASE = SH_W'(2 * EMAX);

    logic [EXP_W-1:0]  op_exp  [2];
    logic [MAN_W-1:0]  op_man  [2];
    logic [FRAC_W-1:0] op_frac [2];
    logic [1:0]        op_live;

    assign op_exp[0] = w_exp;
    assign op_exp[1] = a_exp;
    assign op_man[0] = w_man;
    assign op_man[1] = a_man;

    // Per-operand hidden-one restore and zero-code detect.
    for (genvar g = 0; g < 2; g++) begin : g_op
        assign op_frac[g] = {1'b1, op_man[g]};
        assign op_live[g] = |op_exp[g];
    end

    logic [PROD_W-1:0] prod;
    logic [SH_W-1:0]   exp_sum;
    logic [SH_W-1:0]   shamt;
    logic [TERM_W-1:0] mag;
    logic              neg;

    always_comb begin
        prod    = PROD_W'(op_frac[0]) * PROD_W'(op_frac[1]);
        exp_sum = SH_W'(op_exp[0]) + SH_W'(op_exp[1]);
        shamt   = SH_BASE - exp_sum;
        mag     = TERM_W'(prod) << shamt;
        neg     = w_sgn ^ a_sgn;
        if (&op_live) begin
            term = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
        end else begin
            term = '0;
        end
    end

endmodule

// File: rtl/lbmac_accum.sv
module lbmac_accum #(
    parameter int TERM_W = 14,
    parameter int ACC_W  = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic                     in_last,
    input  logic signed [TERM_W:0]   term,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_psum
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    done;
        logic                    vld;
        logic signed [ACC_W-1:0] psum;
    } st_t;

    st_t st_d, st_q;
    logic signed [ACC_W-1:0] base;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = st_q.done;
        st_d.done = 1'b0;
        base      = in_first ? '0 : st_q.acc;
        if (st_q.done) begin
            st_d.psum = st_q.acc;
        end
        if (in_valid) begin
            st_d.acc  = base + ACC_W'(term);
            st_d.done = in_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_psum  = st_q.psum;

endmodule

// File: rtl/lowbit_group_mac.sv
module lowbit_group_mac
    import lbmac_pkg::*;
#(
    parameter int EXP_W = 2,
    parameter int MAN_W = 4,
    parameter int KER   = 3,
    parameter int ACC_W = term_width(EXP_W, MAN_W) + $clog2(KER * KER) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic                    w_sgn,
    input  logic [EXP_W-1:0]        w_exp,
    input  logic [MAN_W-1:0]        w_man,
    input  logic                    a_sgn,
    input  logic [EXP_W-1:0]        a_exp,
    input  logic [MAN_W-1:0]        a_man,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_psum
);
    localparam int TERM_W = term_width(EXP_W, MAN_W);

    logic signed [TERM_W:0] term;

    lbmac_term #(
        .EXP_W  (EXP_W),
        .MAN_W  (MAN_W),
        .TERM_W (TERM_W)
    ) u_term (
        .w_sgn (w_sgn),
        .w_exp (w_exp),
        .w_man (w_man),
        .a_sgn (a_sgn),
        .a_exp (a_exp),
        .a_man (a_man),
        .term  (term)
    );

    lbmac_accum #(
        .TERM_W (TERM_W),
        .ACC_W  (ACC_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_last   (in_last),
        .term      (term),
        .out_valid (out_valid),
        .out_psum  (out_psum)
    );

endmodule

// File: rtl/lowbit_group_mac_chk.sv
module lowbit_group_mac_chk #(
    parameter int EXP_W = 2,
    parameter int MAN_W = 4,
    parameter int KER   = 3,
    parameter int ACC_W = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_first,
    input logic                    in_last,
    input logic [EXP_W-1:0]        w_exp,
    input logic [EXP_W-1:0]        a_exp,
    input logic                    out_valid,
    input logic signed [ACC_W-1:0] out_psum
);
    localparam int     EMAX   = (1 << EXP_W) - 1;
    localparam longint FMAX   = (longint'(1) << (MAN_W + 1)) - 1;
    localparam longint TMAX   = FMAX * FMAX * (longint'(1) << (2 * EMAX - 2));
    localparam longint BOUND  = TMAX * KER * KER;

    AST_LAST_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ##1 out_valid); // R6

    AST_OUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last, 2)); // R6

    AST_PSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_psum)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(out_psum) <= BOUND && longint'(out_psum) >= -BOUND)); // R8

    AST_ZERO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && in_last && (w_exp == '0 || a_exp == '0))
            |=> ##1 (out_psum == '0)); // R2

endmodule

bind lowbit_group_mac lowbit_group_mac_chk #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .KER   (KER),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .w_exp     (w_exp),
    .a_exp     (a_exp),
    .out_valid (out_valid),
    .out_psum  (out_psum)
);

// File: tb/lowbit_group_mac_tb.sv
module lowbit_group_mac_tb;
    localparam int EW   = 2;
    localparam int MW   = 4;
    localparam int K    = 3;
    localparam int TW   = 2 * MW + (1 << (EW + 1)) - 2;
    localparam int AW   = TW + $clog2(K * K) + 1;
    localparam int EMAX = (1 << EW) - 1;
    localparam int QN   = 32768;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0, in_first = 0, in_last = 0;
    logic          w_sgn = 0, a_sgn = 0;
    logic [EW-1:0] w_exp = 0, a_exp = 0;
    logic [MW-1:0] w_man = 0, a_man = 0;
    logic          out_valid;
    logic signed [AW-1:0] out_psum;

    int     n_vec = 0;
    int     n_bad = 0;
    int     wr = 0, rd = 0;
    longint exp_val [QN];
    string  exp_tag [QN];
    bit     done_flag = 0;
    bit [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    lowbit_group_mac u_dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_first (in_first), .in_last (in_last),
        .w_sgn (w_sgn), .w_exp (w_exp), .w_man (w_man),
        .a_sgn (a_sgn), .a_exp (a_exp), .a_man (a_man),
        .out_valid (out_valid), .out_psum (out_psum)
    );

    function automatic longint tval(bit ws, int we, int wm, bit as, int ae, int am);
        longint m;
        if (we == 0 || ae == 0) return 0;
        m = longint'((1 << MW) + wm) * longint'((1 << MW) + am)
            * (longint'(1) << (2 * EMAX - we - ae));
        return (ws ^ as) ? -m : m;
    endfunction

    function automatic bit [31:0] step(bit [31:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        return s;
    endfunction

    task automatic check(string tag, longint got, longint expv);
        n_vec++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic push(longint v, string tag);
        exp_val[wr] = v;
        exp_tag[wr] = tag;
        wr++;
    endtask

    task automatic send(bit f, bit l, bit ws, int we, int wm, bit as, int ae, int am);
        @(negedge clk);
        in_valid = 1; in_first = f; in_last = l;
        w_sgn = ws; w_exp = EW'(we); w_man = MW'(wm);
        a_sgn = as; a_exp = EW'(ae); a_man = MW'(am);
    endtask

    // Idle cycle carrying garbage that must be ignored (R5).
    task automatic idle();
        @(negedge clk);
        lfsr = step(lfsr);
        in_valid = 0; in_first = lfsr[0]; in_last = lfsr[1];
        w_sgn = lfsr[2]; w_exp = lfsr[4:3]; w_man = lfsr[8:5];
        a_sgn = lfsr[9]; a_exp = lfsr[11:10]; a_man = lfsr[15:12];
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) idle();
    endtask

    // Group of n pseudo-random pairs, optional garbage gaps between them.
    task automatic rgroup(int n, bit gaps, string tag);
        longint sum = 0;
        for (int i = 0; i < n; i++) begin
            bit ws, as; int we, wm, ae, am;
            lfsr = step(lfsr);
            ws = lfsr[0]; we = int'(lfsr[2:1]); wm = int'(lfsr[6:3]);
            as = lfsr[7]; ae = int'(lfsr[9:8]); am = int'(lfsr[13:10]);
            sum += tval(ws, we, wm, as, ae, am);
            if (i == n - 1) push(sum, tag);
            send(i == 0, i == n - 1, ws, we, wm, as, ae, am);
            if (gaps && lfsr[20]) idle();
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Result monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd < wr) begin
                check(exp_tag[rd], longint'(out_psum), exp_val[rd]);
                rd++;
            end else begin
                n_vec++; n_bad++;
                $display("FAIL R6 unexpected out_valid got 1 expected 0");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        finish_run();
    end

    initial begin
        longint hold;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 out_valid in reset", longint'(out_valid), 0);
        check("R9 out_psum in reset", longint'(out_psum), 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 out_valid after reset", longint'(out_valid), 0);

        // R1 R2 R3: every code pair as a one-pair group, streamed back to back (R10)
        for (int w = 0; w < 128; w++) begin
            for (int a = 0; a < 128; a++) begin
                bit ws, as; int we, wm, ae, am;
                ws = w[6]; we = (w >> 4) & 3; wm = w & 15;
                as = a[6]; ae = (a >> 4) & 3; am = a & 15;
                if (we == 0 || ae == 0)      push(0, "R2 zero code");
                else if (ws != as)           push(tval(ws, we, wm, as, ae, am), "R3 mixed sign");
                else                         push(tval(ws, we, wm, as, ae, am), "R1 product shift");
                send(1, 1, ws, we, wm, as, ae, am);
            end
        end
        drain();

        // R6: exact latency of a single isolated pair
        send(1, 1, 0, 1, 0, 0, 1, 0);
        push(tval(0, 1, 0, 0, 1, 0), "R6 latency value");
        idle();
        check("R6 not yet after one edge", longint'(out_valid), 0);
        idle();
        check("R6 valid after two edges", longint'(out_valid), 1);
        idle();
        check("R6 single cycle pulse", longint'(out_valid), 0);
        drain();

        // R5: full groups with garbage gaps
        for (int g = 0; g < 40; g++) rgroup(K * K, 1, "R5 group sum with gaps");
        drain();

        // R10: full groups back to back
        for (int g = 0; g < 20; g++) rgroup(K * K, 0, "R10 back to back group");
        drain();

        // R8: full-scale positive and negative groups
        for (int i = 0; i < K * K; i++) send(i == 0, i == K * K - 1, 0, 1, 15, 0, 1, 15);
        push(138384, "R8 full scale positive");
        for (int i = 0; i < K * K; i++) send(i == 0, i == K * K - 1, 1, 1, 15, 0, 1, 15);
        push(-138384, "R8 full scale negative");
        drain();

        // R4: unfinished group abandoned, new first discards it
        send(1, 0, 0, 1, 15, 0, 1, 15);
        send(0, 0, 0, 1, 15, 0, 1, 15);
        send(0, 0, 0, 1, 15, 0, 1, 15);
        send(1, 0, 0, 2, 3, 1, 3, 7);
        send(0, 1, 0, 3, 0, 0, 3, 0);
        push(tval(0, 2, 3, 1, 3, 7) + tval(0, 3, 0, 0, 3, 0), "R4 first clears");
        drain();

        // R7: value held while idle
        hold = longint'(out_psum);
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R7 out_valid low when idle", longint'(out_valid), 0);
            check("R7 out_psum held", longint'(out_psum), hold);
        end

        if (rd != wr) begin
            n_bad++;
            $display("FAIL R6 results got %0d expected %0d", rd, wr);
        end
        finish_run();
    end

endmodule